// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the digital timing and counting of a dual-slope analog-to-digital converter. The integrator and the comparator sit outside it, in the analog domain. A start request begins a conversion in three steps. First the integrator is discharged for a fixed number of clocks. Then the unknown input is switched onto the integrator for exactly 2^N clocks. Last, a reference of opposite polarity is switched on, and the block counts clocks until the comparator reports that the integrator output has fallen back through zero.

The count taken in the last step is the digital result. The input-to-reference ratio equals that count divided by 2^N, so no feedback DAC is needed. If the integrator has not crossed zero after 2^N reference clocks, the result saturates at full scale and an overrange flag is raised. A full conversion therefore takes at most the discharge time plus 2^(N+1) clocks. When a conversion ends, a one-cycle done pulse goes out together with the new code, and the code stays fixed until the next conversion finishes.

Top module: `dslope_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all three switch selects, `done_o`, `over_o` and `code_o` are 0.
- R2: A `start_i` sampled high while idle makes `zero_sel_o` go high in the next cycle. It stays high for exactly ZERO_CYCLES consecutive cycles, and no other select is high before or during that window.
- R3: In the cycle after the discharge window ends, `in_sel_o` goes high and stays high for exactly 2^N_BITS consecutive cycles. `ref_sel_o` follows in the very next cycle.
- R4: `ref_sel_o` stays high until a rising clock edge samples `cmp_above_i` low. `ref_sel_o` is high in the cycle of that edge, and the edge is the last one of the phase. The code is the number of earlier run-down edges, all of which sampled `cmp_above_i` high. With an ideal integrator this code is ceil(2^N_BITS·vin/vref).
- R5: If `cmp_above_i` is still high at the 2^N_BITS-th run-down edge, the run-down phase ends at that edge, `code_o` becomes all ones (2^N_BITS−1) and `over_o` becomes 1. A conversion that ends through a comparator crossing sets `over_o` to 0.
- R6: At most one of `zero_sel_o`, `in_sel_o` and `ref_sel_o` is high in any cycle.
- R7: `done_o` is high for exactly one cycle, the cycle after the last run-down edge. `code_o` and `over_o` take their new values in that same cycle and keep them until the next `done_o`.
- R8: `start_i` has no effect while a conversion is in progress. Phase lengths, the code and the number of done pulses match a conversion that had no such request.
- R9: `cmp_above_i` is ignored outside the run-down phase. A zero input, which leaves the comparator low through run-up, still gives a full 2^N_BITS run-up and code 0 after a single reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted only when idle |
| cmp_above_i | input | 1 | Comparator: 1 while the integrator output is above zero |
| zero_sel_o | output | 1 | Integrator discharge switch |
| in_sel_o | output | 1 | Input switch (run-up) |
| ref_sel_o | output | 1 | Reference switch (run-down) |
| code_o | output | N_BITS | Run-down count, held between conversions |
| over_o | output | 1 | Overrange flag of the last conversion |
| done_o | output | 1 | One-cycle pulse: conversion finished |

## Verification
The bench drives the comparator from an ideal accumulator and aims at three places. The first is the full-scale boundary, with inputs on both sides of the point where the count reaches 2^N_BITS. A design that is off by one at saturation would either flag a 255 code as overrange or wrap to 0. The second is a zero input, where a design that samples the comparator too early ends run-up at once or reports a nonzero code. The third is start requests arriving during run-up and run-down, which a design that fails to ignore them would show as a restarted phase, a changed code or an extra done pulse. Phase lengths are counted cycle by cycle, so a run-up one clock short shows up as a miscount and as a scaled code.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ZERO  = 2'd1,
    PH_RUNUP = 2'd2,
    PH_RUNDN = 2'd3
  } phase_t;

  // true on the final cycle of a window that is span cycles long
  function automatic logic is_last(input int unsigned count, input int unsigned span);
    return count == span - 1;
  endfunction

  // code reported at the end of run-down
  function automatic int unsigned rundown_code(input int unsigned count,
                                               input logic saturated,
                                               input int unsigned max_code);
    return saturated ? max_code : count;
  endfunction

endpackage

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
  import dslope_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept_i,
  input  logic   zero_end_i,
  input  logic   runup_end_i,
  input  logic   rundn_end_i,
  output phase_t phase_o
);

  phase_t phase_nxt;

  always_comb begin
    phase_nxt = phase_o;
    unique case (phase_o)
      PH_IDLE:  if (accept_i)    phase_nxt = PH_ZERO;
      PH_ZERO:  if (zero_end_i)  phase_nxt = PH_RUNUP;
      PH_RUNUP: if (runup_end_i) phase_nxt = PH_RUNDN;
      PH_RUNDN: if (rundn_end_i) phase_nxt = PH_IDLE;
      default:                   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_o <= PH_IDLE;
    else        phase_o <= phase_nxt;
  end

endmodule

// File: rtl/dslope_tick_counter.sv
module dslope_tick_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [CW-1:0] count_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (run_i)   count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/dslope_result_hold.sv
module dslope_result_hold #(
  parameter int unsigned NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish_i,
  input  logic          sat_i,
  input  logic [NB-1:0] count_i,
  output logic [NB-1:0] code_o,
  output logic          over_o,
  output logic          done_o
);

  localparam int unsigned MAX_CODE = (2 ** NB) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      over_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        code_o <= NB'(dslope_pkg::rundown_code(32'(count_i), sat_i, MAX_CODE));
        over_o <= sat_i;
      end
    end
  end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int unsigned N_BITS      = 8,
  parameter int unsigned ZERO_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_above_i,
  output logic              zero_sel_o,
  output logic              in_sel_o,
  output logic              ref_sel_o,
  output logic [N_BITS-1:0] code_o,
  output logic              over_o,
  output logic              done_o
);

  localparam int unsigned RUNUP_LEN = 2 ** N_BITS;
  localparam int unsigned ZW        = $clog2(ZERO_CYCLES + 1);
  localparam int unsigned CW        = (ZW > N_BITS + 1) ? ZW : N_BITS + 1;

  phase_t        phase;
  logic [CW-1:0] cnt;

  // named phase events, also observed by the checker
  logic ev_accept, ev_zero_end, ev_runup_end, ev_cross, ev_sat, ev_finish;

  assign ev_accept    = (phase == PH_IDLE)  && start_i;
  assign ev_zero_end  = (phase == PH_ZERO)  && is_last(32'(cnt), ZERO_CYCLES);
  assign ev_runup_end = (phase == PH_RUNUP) && is_last(32'(cnt), RUNUP_LEN);
  assign ev_cross     = (phase == PH_RUNDN) && !cmp_above_i;
  assign ev_sat       = (phase == PH_RUNDN) && cmp_above_i && is_last(32'(cnt), RUNUP_LEN);
  assign ev_finish    = ev_cross || ev_sat;

  dslope_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (ev_accept),
    .zero_end_i (ev_zero_end),
    .runup_end_i(ev_runup_end),
    .rundn_end_i(ev_finish),
    .phase_o    (phase)
  );

  dslope_tick_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(ev_accept || ev_zero_end || ev_runup_end || ev_finish),
    .run_i  (phase != PH_IDLE),
    .count_o(cnt)
  );

  dslope_result_hold #(.NB(N_BITS)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .finish_i(ev_finish),
    .sat_i   (ev_sat),
    .count_i (cnt[N_BITS-1:0]),
    .code_o  (code_o),
    .over_o  (over_o),
    .done_o  (done_o)
  );

  assign zero_sel_o = (phase == PH_ZERO);
  assign in_sel_o   = (phase == PH_RUNUP);
  assign ref_sel_o  = (phase == PH_RUNDN);

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int unsigned N_BITS      = 8,
  parameter int unsigned ZERO_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cmp_above_i,
  input logic              zero_sel_o,
  input logic              in_sel_o,
  input logic              ref_sel_o,
  input logic [N_BITS-1:0] code_o,
  input logic              over_o,
  input logic              done_o,
  input logic              ev_sat
);

  localparam int unsigned RUNUP_LEN = 2 ** N_BITS;

  logic [31:0] zlen, ulen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zlen <= '0;
      ulen <= '0;
    end else begin
      zlen <= zero_sel_o ? zlen + 1 : '0;
      ulen <= in_sel_o   ? ulen + 1 : '0;
    end
  end

  assert_sel_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({zero_sel_o, in_sel_o, ref_sel_o}));

  assert_zero_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_sel_o) |-> (zlen == ZERO_CYCLES) && in_sel_o);

  assert_runup_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sel_o) |-> (ulen == RUNUP_LEN) && ref_sel_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o) && $stable(over_o));

  assert_done_after_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ref_sel_o) && !ref_sel_o);

  assert_cross_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !over_o) |-> !$past(cmp_above_i));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sat |=> over_o && done_o && (code_o == {N_BITS{1'b1}}));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel_o && start_i) |=> (in_sel_o || ref_sel_o));

endmodule

bind dslope_seq dslope_seq_chk #(.N_BITS(N_BITS), .ZERO_CYCLES(ZERO_CYCLES)) u_chk (.*);

// File: tb/tb_dslope_seq.sv
`timescale 1ns/1ps
module tb_dslope_seq;

  localparam int NB    = 8;
  localparam int ZC    = 4;
  localparam int RUNUP = 2 ** NB;
  localparam int MAXC  = RUNUP - 1;
  localparam int VREF  = 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cmp_above, zsel, isel, rsel, over, done;
  logic [NB-1:0] code;

  int total = 0, bad = 0, cyc = 0;
  int vin = 0, acc = 0;

  always #2 clk = ~clk;

  dslope_seq #(.N_BITS(NB), .ZERO_CYCLES(ZC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_above_i(cmp_above),
    .zero_sel_o(zsel), .in_sel_o(isel), .ref_sel_o(rsel),
    .code_o(code), .over_o(over), .done_o(done)
  );

  // ideal integrator: one step per clock, driven by the switch selects
  always @(posedge clk) begin
    if (zsel)      acc <= 0;
    else if (isel) acc <= acc + vin;
    else if (rsel) acc <= acc - VREF;
  end
  assign cmp_above = (acc > 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int v);
    return (RUNUP * v + VREF - 1) / VREF;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_conv(input int v, input bit poke);
    int zc = 0, uc = 0, rc = 0, order_bad = 0, both = 0, m, ec, er;
    bit eo;
    logic [NB-1:0] held;
    vin = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 3 * RUNUP + 50; k++) begin
      if (done) break;
      if (zsel && (uc > 0 || rc > 0)) order_bad++;
      if (isel && rc > 0) order_bad++;
      if ((zsel + isel + rsel) > 1) both++;
      zc += zsel; uc += isel; rc += rsel;
      start = poke && ((uc == 10) || (rc == 2));
      @(negedge clk);
    end
    start = 1'b0;
    m  = exp_count(v);
    eo = (m > MAXC);
    ec = eo ? MAXC : m;
    er = eo ? RUNUP : m + 1;
    chk(done === 1'b1, "R7 done seen", done, 1);
    chk(zc == ZC && order_bad == 0, "R2 discharge length", zc, ZC);
    chk(uc == RUNUP, "R3 run-up length", uc, RUNUP);
    chk(rc == er, eo ? "R5 run-down length" : "R4 run-down length", rc, er);
    chk(int'(code) == ec, eo ? "R5 code" : (v == 0 ? "R9 code" : "R4 code"), code, ec);
    chk(over === eo, "R5 over flag", over, eo);
    chk(both == 0, "R6 selects exclusive", both, 0);
    if (poke) chk(int'(code) == ec && rc == er, "R8 start ignored while busy", code, ec);
    held = code;
    vin = $urandom_range(0, VREF);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(code == held && over === eo && done === 1'b0, "R7 code held", code, held);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({zsel, isel, rsel, done, over} == 5'b0 && code == '0, "R1 reset state", code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({zsel, isel, rsel, done, over} == 5'b0 && code == '0, "R1 after reset", code, 0);
    run_conv(500, 1'b0);   // 128
    run_conv(0,   1'b0);   // R9: zero input
    run_conv(1,   1'b0);   // smallest nonzero code
    run_conv(996, 1'b0);   // 255, just below full scale
    run_conv(997, 1'b0);   // R5: overrange
    run_conv(1000, 1'b1);  // R5 + R8
    run_conv(250, 1'b1);   // R8
    for (int i = 0; i < 16; i++) run_conv($urandom_range(0, VREF), i[0]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule